// File: doc/BRIEF.md
# Hypercube Node Router with Dimension-Ordered Correction

This block is the switching element of one node in a binary hypercube of `DIM` dimensions. It has `DIM` link inputs and `DIM` link outputs, one pair per dimension, plus one local injection input and one local ejection output. Every port carries a single-flit packet under a valid/ready handshake. Each packet holds a payload, a destination node address and a hop counter.

Each input has a one-flit holding register. For the flit in that register, the router XORs the destination with the node's own address (`own_addr`). If the result is zero, the flit goes out on the ejection port. Otherwise it leaves on the link of the lowest dimension in which the two addresses still disagree. Because every node corrects the lowest remaining difference first, a packet crosses dimensions in strictly rising order. Its path length equals the Hamming distance between source and destination, and no cyclic channel dependency can form.

When several inputs want the same output, a round-robin arbiter for that output picks one of them. Each forward over a link adds one to the hop counter.

Top module: `ecube_node_router`

## Requirements
- R1: While reset is asserted, and right after it is released, every output valid is low and every input ready is high.
- R2: When a buffered flit's destination equals `own_addr`, the flit leaves on output port `DIM` (ejection). Its hop field, destination and payload are unchanged.
- R3: When the destination differs from `own_addr`, the flit leaves on output port k, where k is the index of the least significant 1 in `own_addr ^ dest`. Output port k (k < `DIM`) is the link over which bit k flips.
- R4: A flit leaving on a link port (index below `DIM`) carries hop field + 1, taken modulo 2^`HOP_W`, with its destination and payload unchanged. The flit layout is: payload in bits [PAY_W-1:0], destination in the next `DIM` bits, hop count in the top `HOP_W` bits.
- R5: A packet injected with hop count 0 and passed node to node until ejection is ejected with hop count equal to popcount(source ^ destination). It crosses dimensions in increasing order, for example 010 to 111 goes over dimension 0 and then dimension 2.
- R6: Each input holds at most one flit. Input ready drops in the cycle after an accept and stays low until the flit leaves. While an output is valid and not ready, its valid and flit stay unchanged.
- R7: Input ports are numbered 0..`DIM` with injection at `DIM`. After reset every output arbiter points at input 0. Among the requesting inputs, the grant goes to the first one found scanning upward from the pointer and wrapping around. After a transfer the pointer moves to the granted input + 1, wrapping.
- R8: A flit accepted at a clock edge is presented on its output port in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | DIM | Address of this node |
| in_valid | input | DIM+1 | Per-input flit valid; bit DIM is injection |
| in_ready | output | DIM+1 | Per-input ready (holding register empty) |
| in_flit | input | (DIM+1)*FW | Input flits, port i in slice i*FW |
| out_valid | output | DIM+1 | Per-output valid; bit DIM is ejection |
| out_ready | input | DIM+1 | Per-output ready from downstream |
| out_flit | output | (DIM+1)*FW | Output flits, port o in slice o*FW |

## Verification
The bench builds the router with `DIM` = 3, `PAY_W` = 8 and `HOP_W` = 3. This gives four inputs competing for each output and destinations up to three hops away.

With these values the bench can reach every route choice, including both the ejection and the highest link. It uses the `own_addr` input to replay a packet at each successive node of a walk, so it can compare the final hop count against the Hamming distance. It can also fill all four inputs toward one output, to follow the pointer through a full rotation and through a wrap that starts from a middle input.

// File: rtl/ecube_pkg.sv
package ecube_pkg;

  // Index of least significant set bit; 32 when the vector is zero.
  function automatic int unsigned low_bit_idx(input logic [31:0] v);
    int unsigned idx;
    idx = 32;
    for (int b = 31; b >= 0; b--) begin
      if (v[b]) idx = b;
    end
    return idx;
  endfunction

endpackage

// File: rtl/ecube_in_slot.sv
module ecube_in_slot #(
  parameter int DIM   = 3,
  parameter int PAY_W = 8,
  parameter int HOP_W = 3,
  localparam int FW    = HOP_W + DIM + PAY_W,
  localparam int NP    = DIM + 1,
  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM-1:0]   own_addr,
  input  logic             in_valid,
  input  logic [FW-1:0]    in_flit,
  input  logic             deq,
  output logic             in_ready,
  output logic             full,
  output logic [FW-1:0]    flit,
  output logic [IDX_W-1:0] port
);
  import ecube_pkg::*;

  logic [DIM-1:0] diff;

  assign in_ready = !full;
  assign diff     = own_addr ^ flit[PAY_W +: DIM];

  always_comb begin
    if (diff == '0) port = IDX_W'(DIM);
    else            port = IDX_W'(low_bit_idx(32'(diff)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      flit <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      flit <= in_flit;
    end else if (deq) begin
      full <= 1'b0;
    end
  end

  // R6: a buffered flit that is not taken stays put
  a_r6_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    full && !deq |=> full && $stable(flit));
  // R8: an accepted flit is held in the next cycle
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> full);

endmodule

// File: rtl/ecube_rr_arb.sv
module ecube_rr_arb #(
  parameter int NP = 4,
  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NP-1:0]    req,
  input  logic             advance,
  output logic [NP-1:0]    grant,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] ptr;
  logic             found;
  int               cand;

  always_comb begin
    grant   = '0;
    gnt_idx = ptr;
    found   = 1'b0;
    cand    = 0;
    for (int off = 0; off < NP; off++) begin
      cand = int'(ptr) + off;
      if (cand >= NP) cand = cand - NP;
      if (!found && req[cand]) begin
        found       = 1'b1;
        grant[cand] = 1'b1;
        gnt_idx     = IDX_W'(cand);
      end
    end
  end

  // Stall parks the pointer on the winner so the offer stays stable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (|req) begin
      if (!advance)                         ptr <= gnt_idx;
      else if (gnt_idx == IDX_W'(NP - 1))   ptr <= '0;
      else                                  ptr <= gnt_idx + IDX_W'(1);
    end
  end

  // R7: at most one winner, and only a requester wins
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r7_grant_req: assert property (@(posedge clk) disable iff (!rst_n)
    |req |-> ((grant & req) == grant) && (grant != '0));

endmodule

// File: rtl/ecube_node_router.sv
module ecube_node_router #(
  parameter int DIM   = 3,
  parameter int PAY_W = 8,
  parameter int HOP_W = 3,
  localparam int FW    = HOP_W + DIM + PAY_W,
  localparam int NP    = DIM + 1,
  localparam int IDX_W = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM-1:0]   own_addr,
  input  logic [NP-1:0]    in_valid,
  output logic [NP-1:0]    in_ready,
  input  logic [NP*FW-1:0] in_flit,
  output logic [NP-1:0]    out_valid,
  input  logic [NP-1:0]    out_ready,
  output logic [NP*FW-1:0] out_flit
);
  localparam int DST_LO = PAY_W;
  localparam int HOP_LO = PAY_W + DIM;

  logic [NP-1:0]    full;
  logic [NP-1:0]    deq;
  logic [FW-1:0]    slot_flit [NP];
  logic [IDX_W-1:0] slot_port [NP];
  logic [NP-1:0]    want      [NP];  // want[i][o]: input i asks for output o
  logic [NP-1:0]    req_o     [NP];  // req_o[o][i]
  logic [NP-1:0]    grant     [NP];
  logic [IDX_W-1:0] gnt_idx   [NP];

  function automatic logic [FW-1:0] bump_hops(input logic [FW-1:0] f);
    logic [FW-1:0] r;
    r = f;
    r[HOP_LO +: HOP_W] = f[HOP_LO +: HOP_W] + HOP_W'(1);
    return r;
  endfunction

  for (genvar i = 0; i < NP; i++) begin : g_in
    ecube_in_slot #(.DIM(DIM), .PAY_W(PAY_W), .HOP_W(HOP_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .own_addr (own_addr),
      .in_valid (in_valid[i]),
      .in_flit  (in_flit[i*FW +: FW]),
      .deq      (deq[i]),
      .in_ready (in_ready[i]),
      .full     (full[i]),
      .flit     (slot_flit[i]),
      .port     (slot_port[i])
    );
    for (genvar o = 0; o < NP; o++) begin : g_want
      assign want[i][o]  = full[i] && (slot_port[i] == IDX_W'(o));
      assign req_o[o][i] = want[i][o];
    end
    // R3: a held flit asks for exactly one output
    a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      full[i] |-> $onehot(want[i]));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [FW-1:0] sel;
    ecube_rr_arb #(.NP(NP)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_o[o]),
      .advance (out_ready[o]),
      .grant   (grant[o]),
      .gnt_idx (gnt_idx[o])
    );
    assign sel          = slot_flit[gnt_idx[o]];
    assign out_valid[o] = |req_o[o];
    if (o < DIM) begin : g_link
      assign out_flit[o*FW +: FW] = bump_hops(sel);
      // R3: link o only carries flits whose address differs lowest at bit o
      a_r3_dim: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |->
          ((out_flit[o*FW + DST_LO +: DIM] ^ own_addr) & ((DIM'(1) << o) | ((DIM'(1) << o) - DIM'(1))))
          == (DIM'(1) << o));
    end else begin : g_eject
      assign out_flit[o*FW +: FW] = sel;
      // R2: only flits addressed to this node are ejected
      a_r2_eject: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[o] |-> out_flit[o*FW + DST_LO +: DIM] == own_addr);
    end
    // R6: a stalled offer does not change
    a_r6_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_flit[o*FW +: FW]));
  end

  always_comb begin
    deq = '0;
    for (int o = 0; o < NP; o++) begin
      for (int i = 0; i < NP; i++) begin
        deq[i] = deq[i] | (grant[o][i] & out_ready[o]);
      end
    end
  end

  // R1: nothing is offered in the first cycle after reset
  a_r1_idle: assert property (@(posedge clk) $rose(rst_n) |-> out_valid == '0);

endmodule

// File: tb/ecube_node_router_test.sv
`timescale 1ns/100ps
module ecube_node_router_test;
  localparam int DIM = 3, PAY_W = 8, HOP_W = 3;
  localparam int FW = HOP_W + DIM + PAY_W, NP = DIM + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIM-1:0]   own_addr = '0;
  logic [NP-1:0]    in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [NP*FW-1:0] in_flit = '0, out_flit;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ecube_node_router #(.DIM(DIM), .PAY_W(PAY_W), .HOP_W(HOP_W)) uut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .in_valid(in_valid),
    .in_ready(in_ready), .in_flit(in_flit), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit(out_flit));

  function automatic logic [FW-1:0] mk(input int h, input int d, input int p);
    return {HOP_W'(h), DIM'(d), PAY_W'(p)};
  endfunction
  function automatic int exp_port(input int a, input int d);
    for (int b = 0; b < DIM; b++) if (((a ^ d) >> b) & 1) return b;
    return DIM;
  endfunction
  function automatic int popc(input int v);
    int c = 0;
    for (int b = 0; b < DIM; b++) c += (v >> b) & 1;
    return c;
  endfunction
  function automatic int one_port();
    int n = 0, p = -1;
    for (int k = 0; k < NP; k++) if (out_valid[k]) begin n++; p = k; end
    return (n == 1) ? p : -1;
  endfunction
  function automatic logic [FW-1:0] oflit(input int k);
    return out_flit[k*FW +: FW];
  endfunction

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic send_one(input int p, input logic [FW-1:0] f);
    @(negedge clk);
    in_valid[p] = 1'b1;
    in_flit[p*FW +: FW] = f;
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = '0; out_ready = '1;
    @(negedge clk);
    chk(out_valid == '0 && in_ready == '1, "R1 in reset", {in_ready, out_valid}, {4'hF, 4'h0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0 && in_ready == '1, "R1 after reset", {in_ready, out_valid}, {4'hF, 4'h0});
  endtask

  task automatic walk(input int src, input int dst, input int pay, output int p0, output int p1);
    logic [FW-1:0] f;
    int cur, p, op, nf;
    bit fin;
    cur = src; own_addr = DIM'(src); f = mk(0, dst, pay); p = DIM; nf = 0; fin = 0;
    p0 = -1; p1 = -1;
    for (int s = 0; s <= DIM + 1 && !fin; s++) begin
      send_one(p, f);
      op = one_port();
      if (op == DIM) begin
        fin = 1;
        chk(int'(oflit(op)[FW-1 -: HOP_W]) == popc(src ^ dst), "R5 hops", oflit(op)[FW-1 -: HOP_W], popc(src ^ dst));
        chk(oflit(op)[PAY_W-1:0] == PAY_W'(pay) && cur == dst, "R2 walk eject", oflit(op)[PAY_W-1:0], pay);
      end else begin
        chk(op == exp_port(cur, dst), "R3 walk port", op, exp_port(cur, dst));
        if (op < 0) fin = 1;
        else begin
          if (nf == 0) p0 = op; else if (nf == 1) p1 = op;
          nf++;
          f = oflit(op);
          @(posedge clk); #1;
          cur = cur ^ (1 << op); own_addr = DIM'(cur); p = op;
        end
      end
    end
    chk(fin && nf <= DIM, "R5 length", nf, popc(src ^ dst));
  endtask

  task automatic rr_expect(input int o, input int pay, input string r);
    chk(out_valid[o] && oflit(o)[PAY_W-1:0] == PAY_W'(pay), r, oflit(o)[PAY_W-1:0], pay);
    out_ready[o] = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0, p1, op, ep, own, dst, ip, h, pay;
    logic [FW-1:0] held;
    void'($urandom(32'd20240611));
    do_reset();

    // R2: destination equals own address
    own_addr = 3'b101;
    send_one(3, mk(2, 3'b101, 8'h5A));
    chk(one_port() == DIM, "R2 eject port", one_port(), DIM);
    chk(oflit(DIM) == mk(2, 3'b101, 8'h5A), "R2 eject flit", oflit(DIM), mk(2, 3'b101, 8'h5A));
    chk(in_ready[3] == 1'b0, "R6 ready low after accept", in_ready[3], 0);

    // R3/R4/R8: highest dimension only
    own_addr = 3'b000;
    send_one(0, mk(1, 3'b100, 8'h11));
    chk(one_port() == 2, "R3 top dim port", one_port(), 2);
    chk(oflit(2) == mk(2, 3'b100, 8'h11), "R4 hop bump", oflit(2), mk(2, 3'b100, 8'h11));
    // R4: hop wrap
    send_one(1, mk(7, 3'b011, 8'h22));
    chk(one_port() == 0 && oflit(0) == mk(0, 3'b011, 8'h22), "R4 hop wrap", oflit(0), mk(0, 3'b011, 8'h22));

    // R6: stall holds flit and ready
    out_ready[1] = 1'b0;
    send_one(1, mk(0, 3'b010, 8'h33));
    held = oflit(1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid[1] && oflit(1) == held && !in_ready[1], "R6 stall hold", oflit(1), held);
    end
    out_ready[1] = 1'b1;
    @(negedge clk);
    chk(out_valid == '0 && in_ready[1], "R6 release", {in_ready, out_valid}, {4'hF, 4'h0});

    // R5: worked example and random walks
    walk(3'b010, 3'b111, 8'h44, p0, p1);
    chk(p0 == 0 && p1 == 2, "R5 order 010->111", {p0[3:0], p1[3:0]}, 8'h02);
    for (int n = 0; n < 40; n++) walk($urandom % 8, $urandom % 8, $urandom % 256, p0, p1);

    // R3/R4/R2 random single hops
    for (int n = 0; n < 200; n++) begin
      own = $urandom % 8; dst = $urandom % 8; ip = $urandom % NP; h = $urandom % 8; pay = $urandom % 256;
      own_addr = DIM'(own);
      send_one(ip, mk(h, dst, pay));
      op = one_port(); ep = exp_port(own, dst);
      chk(op == ep, "R3 random port", op, ep);
      if (op >= 0)
        chk(oflit(op) == mk((ep < DIM) ? h + 1 : h, dst, pay), "R4 random flit", oflit(op), mk((ep < DIM) ? h + 1 : h, dst, pay));
    end

    // R7: all inputs to one output, pointer starts at 0
    do_reset();
    own_addr = 3'b000; out_ready[2] = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      in_valid[i] = 1'b1; in_flit[i*FW +: FW] = mk(0, 3'b100, 8'hA0 + i);
    end
    @(negedge clk);
    in_valid = '0;
    for (int i = 0; i < NP; i++) rr_expect(2, 8'hA0 + i, "R7 rotation");
    chk(out_valid == '0, "R7 drained", out_valid, 0);
    // R7: wrap from a middle input
    send_one(2, mk(0, 3'b100, 8'hB2));
    @(negedge clk);
    out_ready[2] = 1'b0;
    for (int i = 0; i < NP; i++) if (i != 2) begin
      in_valid[i] = 1'b1; in_flit[i*FW +: FW] = mk(0, 3'b100, 8'hB0 + i);
    end
    @(negedge clk);
    in_valid = '0;
    rr_expect(2, 8'hB3, "R7 wrap first");
    out_ready[2] = 1'b0;
    rr_expect(2, 8'hB0, "R7 wrap second");
    rr_expect(2, 8'hB1, "R7 wrap third");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule